// File: doc/BRIEF.md
# B3ZS/HDB3 Line Encoder with Bypass

This block sits on the transmit side of a DS3, STS-1 or E3 line interface. In binary mode it takes one serial data bit per clock and turns it into a pair of unipolar outputs, one for positive pulses and one for negative pulses. Ones become marks of alternating polarity. Runs of zeros are replaced with substitution codes that contain a deliberate bipolar violation. DS3 and STS-1 lines use three-zero substitution (B3ZS). E3 lines use four-zero substitution (HDB3).

In bipolar mode the encoder is bypassed. The two inputs are already a positive/negative pulse pair, and they go to the outputs after one register stage. A sampling-edge control chooses whether inputs are captured on the rising or the falling clock edge. All other logic runs on the rising edge.

A small mode state machine tracks the requested mode. Its states are ST_BYPASS (`bin_mode`=0), ST_B3ZS (`bin_mode`=1, `e3_mode`=0) and ST_HDB3 (`bin_mode`=1, `e3_mode`=1). Its single transition, MODE_SWITCH, fires whenever the request differs from the held state. MODE_SWITCH flushes the pipeline and the polarity state in the same way a reset does.

Each pipeline slot holds one of five symbol kinds:
- SYM_NONE: empty slot.
- SYM_ZERO: a data zero.
- SYM_MARK: a data one.
- SYM_BPULSE: a balancing pulse inserted by substitution.
- SYM_VPULSE: a violation pulse inserted by substitution.

Top module: `bipolar_line_encoder`

## Requirements
- R1: With `bin_mode`=1, the data bit is taken from `tx_data_pos` alone, and `tx_neg` has no effect on the outputs.
- R2: In binary mode, successive pulses (marks and balancing pulses) alternate polarity. The first pulse after reset or a mode switch is positive (`line_pos`=1).
- R3: With `e3_mode`=0, every run of three data zeros is replaced.
  - If an odd number of pulses has been sent since the last violation, the run becomes 0,0,V.
  - If that number is even, the run becomes B,0,V.
- R4: With `e3_mode`=1, every run of four data zeros is replaced.
  - If the pulse count since the last violation is odd, the run becomes 0,0,0,V.
  - If that count is even, the run becomes B,0,0,V.
- R5: Violation and balancing pulses both update the running polarity.
  - A violation pulse V takes the same polarity as the pulse before it.
  - A balancing pulse B takes the opposite polarity of the pulse before it.
  - After a V, the pulse count since the last violation restarts at zero.
- R6: A bit sampled at clock edge e drives the outputs from edge e+N+1, where N is 3 in B3ZS mode and 4 in HDB3 mode. In bypass mode it drives them from edge e+1.
- R7: With `bin_mode`=0, the outputs carry the sampled pair as follows.
  - `tx_data_pos`=1 with `tx_neg`=0 gives a positive pulse.
  - `tx_neg`=1 with `tx_data_pos`=0 gives a negative pulse.
  - Both high gives no pulse.
  - Both low gives no pulse.
- R8: With `fall_edge`=0, inputs are sampled on the rising clock edge. With `fall_edge`=1, they are sampled on the preceding falling edge.
- R9: While the synchronous reset `rst` is high, both outputs are low. After reset, the polarity state gives a positive first pulse and the violation parity is even.
- R10: `line_pos` and `line_neg` are never high together.
- R11: A change of the requested mode without reset (MODE_SWITCH) clears the pipeline and the polarity state. Encoding then continues as it would after a reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bin_mode | input | 1 | 1: encode serial data; 0: bypass with a pre-encoded pair |
| e3_mode | input | 1 | 1: HDB3 (E3); 0: B3ZS (DS3/STS-1) |
| fall_edge | input | 1 | 1: sample inputs on the falling edge |
| tx_data_pos | input | 1 | Serial data (binary mode) or positive pulse (bypass) |
| tx_neg | input | 1 | Negative pulse (bypass); ignored in binary mode |
| line_pos | output | 1 | Positive pulse to the line driver |
| line_neg | output | 1 | Negative pulse to the line driver |

## Verification
A behavioural encoder in the bench is compared with the outputs on every clock. It is driven with several kinds of input:
- All ones isolates plain mark alternation.
- All zeros exercises back-to-back substitutions whose parity is even.
- Sparse ones, and ones separated by runs of three and four zeros, separate the odd-parity substitution from the even-parity one and the 3-zero window from the 4-zero window.
- A long pseudo-random stream, with random activity on the ignored negative input, mixes every case.

Short fixed sequences are also checked against hand-derived pulse lists. A glitch pattern changes the inputs between the falling and the rising edge, so the two sampling-edge settings must give visibly different results. Bypass runs include the both-high pair, and mode switches without reset show the flush.

// File: rtl/lenc_pkg.sv
`timescale 1ns/1ps
package lenc_pkg;

    // Kind of symbol held in one slot of the lookahead pipeline
    typedef enum logic [2:0] {
        SYM_NONE,
        SYM_ZERO,
        SYM_MARK,
        SYM_BPULSE,
        SYM_VPULSE
    } sym_t;

    // Operating mode held by the mode state machine
    typedef enum logic [1:0] {
        ST_BYPASS,
        ST_B3ZS,
        ST_HDB3
    } mode_t;

endpackage

// File: rtl/lenc_sampler.sv
`timescale 1ns/1ps
module lenc_sampler (
    input  logic clk,
    input  logic rst,
    input  logic fall_edge,
    input  logic pos_in,
    input  logic neg_in,
    output logic cap_pos,
    output logic cap_neg,
    output logic cap_vld
);

    logic fall_pos_q;
    logic fall_neg_q;

    // Falling-edge capture, used when the inverted sampling edge is selected
    always_ff @(negedge clk) begin
        fall_pos_q <= pos_in;
        fall_neg_q <= neg_in;
    end

    // Rising-edge register that hands the chosen sample to the rest of the block
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_pos <= 1'b0;
            cap_neg <= 1'b0;
            cap_vld <= 1'b0;
        end else begin
            cap_pos <= fall_edge ? fall_pos_q : pos_in;
            cap_neg <= fall_edge ? fall_neg_q : neg_in;
            cap_vld <= 1'b1;
        end
    end

endmodule

// File: rtl/lenc_mode_fsm.sv
`timescale 1ns/1ps
module lenc_mode_fsm #(
    parameter int B3ZS_RUN = 3,
    parameter int HDB3_RUN = 4,
    parameter int RW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bin_mode,
    input  logic          e3_mode,
    output logic          flush,
    output logic          bypass,
    output logic [RW-1:0] run_len
);
    import lenc_pkg::*;

    mode_t state_q;
    mode_t mode_req;

    // Requested state from the mode inputs
    always_comb begin
        unique case ({bin_mode, e3_mode})
            2'b10:   mode_req = ST_B3ZS;
            2'b11:   mode_req = ST_HDB3;
            default: mode_req = ST_BYPASS;
        endcase
    end

    // State register: reset loads the request, MODE_SWITCH follows it
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= mode_req;
        end else begin
            state_q <= mode_req;
        end
    end

    // MODE_SWITCH transition: request differs from held state
    assign flush = !rst && (state_q != mode_req);

    // State outputs
    always_comb begin
        unique case (state_q)
            ST_B3ZS: begin
                bypass  = 1'b0;
                run_len = RW'(B3ZS_RUN);
            end
            ST_HDB3: begin
                bypass  = 1'b0;
                run_len = RW'(HDB3_RUN);
            end
            default: begin
                bypass  = 1'b1;
                run_len = RW'(B3ZS_RUN);
            end
        endcase
    end

endmodule

// File: rtl/lenc_subst_pipe.sv
`timescale 1ns/1ps
module lenc_subst_pipe #(
    parameter int DEPTH = 4,
    parameter int RW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_vld,
    input  logic             in_bit,
    input  logic [RW-1:0]    run_len,
    input  logic             parity_odd,
    output lenc_pkg::sym_t   head
);
    import lenc_pkg::*;

    sym_t stage_q [DEPTH];
    sym_t stage_d [DEPTH];
    sym_t in_sym;
    logic win_zero;

    always_comb begin
        in_sym = !in_vld ? SYM_NONE : (in_bit ? SYM_MARK : SYM_ZERO);

        // Window: the incoming symbol plus stages 1..run_len-1, all plain zeros
        win_zero = (in_sym == SYM_ZERO);
        for (int i = 1; i < DEPTH; i++) begin
            if (i < int'(run_len)) begin
                win_zero = win_zero && (stage_q[i] == SYM_ZERO);
            end
        end

        for (int i = 0; i < DEPTH; i++) begin
            if (i + 1 < int'(run_len)) begin
                stage_d[i] = stage_q[i + 1];
            end else if (i + 1 == int'(run_len)) begin
                stage_d[i] = win_zero ? SYM_VPULSE : in_sym;
            end else begin
                stage_d[i] = SYM_NONE;
            end
        end

        // Even pulse count since last violation: balance the first zero of the run
        if (win_zero && !parity_odd) begin
            stage_d[0] = SYM_BPULSE;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || flush) begin
                stage_q[i] <= SYM_NONE;
            end else begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign head = stage_q[0];

endmodule

// File: rtl/lenc_polarity.sv
`timescale 1ns/1ps
module lenc_polarity (
    input  logic           clk,
    input  logic           rst,
    input  logic           flush,
    input  logic           bypass,
    input  lenc_pkg::sym_t head,
    input  logic           cap_pos,
    input  logic           cap_neg,
    output logic           parity_odd,
    output logic           last_pos,
    output logic           line_pos,
    output logic           line_neg
);
    import lenc_pkg::*;

    logic parity_q;
    logic pol_d;
    logic emit_pos;
    logic emit_neg;

    always_comb begin
        pol_d      = last_pos;
        parity_odd = parity_q;
        emit_pos   = 1'b0;
        emit_neg   = 1'b0;
        unique case (head)
            SYM_MARK, SYM_BPULSE: begin
                pol_d      = !last_pos;
                parity_odd = !parity_q;
                emit_pos   = !last_pos;
                emit_neg   = last_pos;
            end
            SYM_VPULSE: begin
                parity_odd = 1'b0;
                emit_pos   = last_pos;
                emit_neg   = !last_pos;
            end
            default: begin
            end
        endcase
    end

    // Running polarity and violation parity
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            last_pos <= 1'b0;
            parity_q <= 1'b0;
        end else if (!bypass) begin
            last_pos <= pol_d;
            parity_q <= parity_odd;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            line_pos <= 1'b0;
            line_neg <= 1'b0;
        end else if (bypass) begin
            line_pos <= cap_pos && !cap_neg;
            line_neg <= cap_neg && !cap_pos;
        end else begin
            line_pos <= emit_pos;
            line_neg <= emit_neg;
        end
    end

endmodule

// File: rtl/bipolar_line_encoder.sv
`timescale 1ns/1ps
module bipolar_line_encoder #(
    parameter int B3ZS_RUN = 3,
    parameter int HDB3_RUN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bin_mode,
    input  logic e3_mode,
    input  logic fall_edge,
    input  logic tx_data_pos,
    input  logic tx_neg,
    output logic line_pos,
    output logic line_neg
);
    import lenc_pkg::*;

    localparam int DEPTH = (HDB3_RUN > B3ZS_RUN) ? HDB3_RUN : B3ZS_RUN;
    localparam int RW    = $clog2(DEPTH + 1);

    logic          cap_pos;
    logic          cap_neg;
    logic          cap_vld;
    logic          flush;
    logic          bypass;
    logic [RW-1:0] run_len;
    logic          parity_odd;
    logic          last_pos;
    sym_t          head_sym;

    lenc_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .fall_edge (fall_edge),
        .pos_in    (tx_data_pos),
        .neg_in    (tx_neg),
        .cap_pos   (cap_pos),
        .cap_neg   (cap_neg),
        .cap_vld   (cap_vld)
    );

    lenc_mode_fsm #(
        .B3ZS_RUN (B3ZS_RUN),
        .HDB3_RUN (HDB3_RUN),
        .RW       (RW)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .bin_mode (bin_mode),
        .e3_mode  (e3_mode),
        .flush    (flush),
        .bypass   (bypass),
        .run_len  (run_len)
    );

    lenc_subst_pipe #(
        .DEPTH (DEPTH),
        .RW    (RW)
    ) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .in_vld     (cap_vld && !bypass),
        .in_bit     (cap_pos),
        .run_len    (run_len),
        .parity_odd (parity_odd),
        .head       (head_sym)
    );

    lenc_polarity u_pol (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .bypass     (bypass),
        .head       (head_sym),
        .cap_pos    (cap_pos),
        .cap_neg    (cap_neg),
        .parity_odd (parity_odd),
        .last_pos   (last_pos),
        .line_pos   (line_pos),
        .line_neg   (line_neg)
    );

endmodule

// File: rtl/bipolar_line_encoder_chk.sv
`timescale 1ns/1ps
module bipolar_line_encoder_chk (
    input logic           clk,
    input logic           rst,
    input logic           bin_mode,
    input logic           fall_edge,
    input logic           tx_data_pos,
    input logic           tx_neg,
    input logic           line_pos,
    input logic           line_neg,
    input logic           flush,
    input lenc_pkg::sym_t head_sym,
    input logic           last_pos
);
    import lenc_pkg::*;

    logic [1:0] age_q;
    logic       rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(line_pos && line_neg)); // R10

    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            AST_RESET_QUIET: assert (!line_pos && !line_neg); // R9
        end
    end

    AST_MARK_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (!flush && (head_sym == SYM_MARK || head_sym == SYM_BPULSE))
        |=> (line_pos == !$past(last_pos)) && (line_pos != line_neg)); // R2

    AST_VIOL_SAME_POL: assert property (@(posedge clk) disable iff (rst)
        (!flush && head_sym == SYM_VPULSE)
        |=> (line_pos == $past(last_pos)) && (line_pos != line_neg)); // R5

    AST_BYPASS_POS: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(!bin_mode, 2) && $past(!bin_mode) &&
         $past(!fall_edge, 2) && $past(tx_data_pos, 2) && $past(!tx_neg, 2))
        |-> (line_pos && !line_neg)); // R7

    AST_BYPASS_NEG: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(!bin_mode, 2) && $past(!bin_mode) &&
         $past(!fall_edge, 2) && $past(!tx_data_pos, 2) && $past(tx_neg, 2))
        |-> (line_neg && !line_pos)); // R7

endmodule

bind bipolar_line_encoder bipolar_line_encoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bin_mode    (bin_mode),
    .fall_edge   (fall_edge),
    .tx_data_pos (tx_data_pos),
    .tx_neg      (tx_neg),
    .line_pos    (line_pos),
    .line_neg    (line_neg),
    .flush       (flush),
    .head_sym    (head_sym),
    .last_pos    (last_pos)
);

// File: tb/bipolar_line_encoder_test.sv
`timescale 1ns/1ps
module bipolar_line_encoder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bin_mode = 1'b1;
    logic e3_mode = 1'b0;
    logic fall_edge = 1'b0;
    logic tx_data_pos = 1'b0;
    logic tx_neg = 1'b0;
    logic line_pos;
    logic line_neg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int obs[$];

    always #2.5 clk = ~clk;

    bipolar_line_encoder uut (
        .clk         (clk),
        .rst         (rst),
        .bin_mode    (bin_mode),
        .e3_mode     (e3_mode),
        .fall_edge   (fall_edge),
        .tx_data_pos (tx_data_pos),
        .tx_neg      (tx_neg),
        .line_pos    (line_pos),
        .line_neg    (line_neg)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // +1 positive pulse, -1 negative pulse, 0 none, 9 both high
    function automatic int line_val();
        if (line_pos && line_neg) return 9;
        if (line_pos) return 1;
        if (line_neg) return -1;
        return 0;
    endfunction

    // Behavioural zero-substitution encoder
    function automatic void encode_ref(input bit bits[$], input int n, output int sym[$]);
        int kind[$];
        int par = 0;
        int run = 0;
        int last = -1;
        sym.delete();
        foreach (bits[j]) begin
            if (bits[j]) begin
                kind.push_back(1);
                par = par ^ 1;
                run = 0;
            end else begin
                kind.push_back(0);
                run++;
                if (run == n) begin
                    if (par == 0) kind[j - n + 1] = 2;
                    kind[j] = 3;
                    par = 0;
                    run = 0;
                end
            end
        end
        foreach (kind[j]) begin
            if (kind[j] == 1 || kind[j] == 2) begin
                last = -last;
                sym.push_back(last);
            end else if (kind[j] == 3) begin
                sym.push_back(last);
            end else begin
                sym.push_back(0);
            end
        end
    endfunction

    task automatic run_stream(input string req, input bit bin, input bit e3, input bit fe,
                              input bit glitch, input bit do_rst, input int pat, input int len);
        bit pq[$];
        bit nq[$];
        int exp[$];
        int d;
        logic [15:0] lf = 16'hACE1;
        logic [9:0] s5 = 10'b1000010000;
        logic [7:0] s6 = 8'b00011000;
        d = !bin ? 2 : (e3 ? 6 : 5);
        for (int j = 0; j < len + d; j++) begin
            bit p;
            bit n;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            n = lf[7];
            if (j >= len) begin
                p = 1'b0;
                n = 1'b0;
            end else begin
                case (pat)
                    0: p = 1'b1;
                    1: p = 1'b0;
                    2: p = lf[0];
                    3: p = (j % 5 == 0);
                    4: p = (j % 9 == 0) || (j % 9 == 4);
                    5: p = s5[9 - j];
                    default: p = s6[7 - j];
                endcase
            end
            pq.push_back(p);
            nq.push_back(n);
        end
        if (bin) begin
            encode_ref(pq, e3 ? 4 : 3, exp);
        end else begin
            foreach (pq[j]) exp.push_back((pq[j] && !nq[j]) ? 1 : ((nq[j] && !pq[j]) ? -1 : 0));
        end
        obs.delete();
        if (do_rst) begin
            rst = 1'b1;
            bin_mode = bin;
            e3_mode = e3;
            fall_edge = fe;
            repeat (2) @(posedge clk);
            #1;
            rst = 1'b0;
        end else begin
            @(posedge clk);
            #1;
            bin_mode = bin;
            e3_mode = e3;
            fall_edge = fe;
        end
        for (int t = 0; t < len + d; t++) begin
            if (glitch) begin
                tx_data_pos = fe ? pq[t] : ~pq[t];
                tx_neg      = fe ? nq[t] : ~nq[t];
            end else begin
                tx_data_pos = pq[t];
                tx_neg      = nq[t];
            end
            #1;
            if (t >= d) begin
                obs.push_back(line_val());
                check(req, line_val(), exp[t - d]);
            end else if (t >= 1) begin
                check(req, line_val(), 0);
            end
            #1.5;
            if (glitch) begin
                tx_data_pos = fe ? ~pq[t] : pq[t];
                tx_neg      = fe ? ~nq[t] : nq[t];
            end
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        int hdb[10];
        int b3[8];
        hdb = '{1, 0, 0, 0, 1, -1, 0, 0, 0, -1};
        b3  = '{1, 0, 1, -1, 1, -1, 0, -1};

        // R9: outputs low during reset
        repeat (2) @(posedge clk);
        #1;
        check("R9 reset pos", int'(line_pos), 0);
        check("R9 reset neg", int'(line_neg), 0);

        // R4 R5 R2: hand-derived HDB3 sequence (odd parity gives 000V)
        run_stream("R4 R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5, 10);
        foreach (hdb[i]) check("R4 R5 R2 hand", obs[i], hdb[i]);

        // R3 R5: hand-derived B3ZS sequence (even parity gives B0V)
        run_stream("R3 R6", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6, 8);
        foreach (b3[i]) check("R3 R5 R9 hand", obs[i], b3[i]);

        // Random data, random activity on ignored negative input
        run_stream("R1 R4 R5 R10", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2, 300);
        run_stream("R1 R3 R5 R10", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2, 300);

        // Pattern families
        run_stream("R2 all ones", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 30);
        run_stream("R4 all zeros", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1, 40);
        run_stream("R3 all zeros", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1, 40);
        run_stream("R3 sparse", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3, 60);
        run_stream("R4 sparse", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3, 60);
        run_stream("R3 runs", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4, 72);
        run_stream("R4 runs", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4, 72);

        // R8: inputs change between falling and rising edge
        run_stream("R8 rise", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2, 80);
        run_stream("R8 fall", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2, 80);
        run_stream("R8 fall steady", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2, 60);

        // R7: bypass, including both-high pairs
        run_stream("R7 R10 bypass", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 120);
        run_stream("R7 R8 bypass fall", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2, 80);

        // R11: mode switches without reset
        run_stream("R11 to HDB3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2, 100);
        run_stream("R11 to B3ZS", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4, 72);
        run_stream("R11 to bypass", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2, 40);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule